// File: doc/BRIEF.md
# Timer Interrupt Router

This block sits between a bank of timer channels and the interrupt fabric. Each channel produces a one-cycle expiry pulse. The block turns that pulse into a level or a pulse on one of 32 interrupt lines, and keeps a per-channel status bit for level-type channels. Software clears a status bit by writing a 1 to it through a strobe.

A compatibility mode can take over two legacy interrupt sources. When the mode is off, the two external legacy inputs are registered and appear on lines 0 and 8. When the mode is on, those inputs are blocked and channel 0 and channel 1 drive lines 0 and 8 instead, whatever their route fields say. A separate output tells the old periodic-tick source whether it may run.

Top module: `tmr_irq_router`

## Requirements
- R1: While the registered compatibility mode is set, channel 0's activity appears on line 0 and channel 1's on line 8, and neither appears on the line named by its route field.
- R2: While the mode is clear, channel i's activity appears on the line whose index is its 5-bit route field `ch_route[5*i +: 5]`.
- R3: An expiry on an enabled level-type channel (`ch_level[i]`=1), with the global enable set, sets status bit i at the next clock edge. The line is held high until the bit clears.
- R4: An expiry on an enabled edge-type channel (`ch_level[i]`=0) raises its line for exactly one cycle after the edge and leaves status bit i at 0.
- R5: A channel whose enable is low, or any channel while the global enable is low, has its status bit cleared and its line lowered at the next edge. Expiries in that state have no effect.
- R6: A status write strobe clears every set status bit whose data bit is 1. Data bits of 0 leave their status bits unchanged. An expiry of a level channel in the same cycle wins over the clear.
- R7: While the mode is clear, line 0 follows legacy input 0 and line 8 follows legacy input 1, each one clock late.
- R8: The mode input is registered. While it is set, both legacy inputs are kept off lines 0 and 8, and `legacy_tick_en` is low. After the mode clears, `legacy_tick_en` is high again and line 8 returns to the latched level of legacy input 1.
- R9: Several sources mapped to the same line are ORed together.
- R10: After reset all lines are low, all status bits are 0, and `legacy_tick_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_expire | input | NUM_CH | One-cycle expiry pulse per channel |
| ch_route | input | NUM_CH*5 | Packed 5-bit route field per channel |
| ch_level | input | NUM_CH | 1 = level type, 0 = edge type |
| ch_enable | input | NUM_CH | Per-channel interrupt enable |
| glb_enable | input | 1 | Global enable |
| compat_mode | input | 1 | Legacy-replacement mode request |
| legacy_in0 | input | 1 | External legacy source for line 0 |
| legacy_in1 | input | 1 | External legacy source for line 8 |
| sts_wr | input | 1 | Status write strobe |
| sts_wdata | input | NUM_CH | Write-one-to-clear data |
| irq_lines | output | 32 | Interrupt lines |
| irq_status | output | NUM_CH | Per-channel status bits |
| legacy_tick_en | output | 1 | Permission for the old tick source |

## Verification
On every cycle, the assertions check the following:
- how status bits set, hold and clear around expiries and strobes;
- that edge expiries never set a status bit;
- that enables force a clear;
- that the tick-enable output tracks the mode;
- that the registered legacy inputs pass through;
- that a set status bit or pulse reaches its routed line.

Only the directed scenarios show the full picture of routing and mode changes. This includes the one-cycle width of edge pulses and the OR of two channels on a shared line. It also covers lines 0 and 8 switching owner across a mode change, the mode's route override leaving the field's line quiet, and line 8 regaining the latched level when the mode ends.

// File: rtl/tir_pkg.sv
// Package: shared sizing for the timer interrupt router.
// Assumes a power-of-two line count so the route field is exactly log2 wide.
package tir_pkg;
    localparam int TIR_LINES  = 32;
    localparam int TIR_LEG_A  = 0;   // line taken by channel 0 / legacy input 0
    localparam int TIR_LEG_B  = 8;   // line taken by channel 1 / legacy input 1
    localparam int TIR_ROUTEW = $clog2(TIR_LINES);
endpackage

// File: rtl/tir_chan_state.sv
// Module: status bit and edge pulse of one timer channel.
// Assumes expire is a single-cycle pulse. Output act is high whenever the
// channel wants its line asserted.
module tir_chan_state (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic ch_en,
    input  logic glb_en,
    input  logic is_level,
    input  logic clr_req,
    output logic sts_q,
    output logic act
);
    logic live;
    logic pls_q;

    assign live = ch_en && glb_en;

    // Status bit: forced clear when not live, set by level expiry, write-one-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q <= 1'b0;
        end else if (!live) begin
            sts_q <= 1'b0;
        end else if (expire && is_level) begin
            sts_q <= 1'b1;
        end else if (clr_req) begin
            sts_q <= 1'b0;
        end
    end

    // Edge pulse: one cycle high after an edge-type expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) pls_q <= 1'b0;
        else        pls_q <= expire && live && !is_level;
    end

    assign act = sts_q || pls_q;

    AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !live |=> !sts_q);                                            // R5
    AST_LEVEL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && live && is_level) |=> sts_q);                      // R3
    AST_EDGE_NO_STS: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !is_level && !sts_q) |=> !sts_q);                  // R4
    AST_W0_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_q && live && !clr_req) |=> sts_q);                       // R6
    AST_W1_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_q && clr_req && !(expire && is_level)) |=> !sts_q);      // R6
endmodule

// File: rtl/tir_route_mux.sv
// Module: maps active channels onto interrupt lines.
// In compatibility mode, channel 0 and channel 1 ignore their route fields.
// Several channels on one line are ORed. The logic is purely combinational.
module tir_route_mux #(
    parameter int NUM_CH    = 4,
    parameter int NUM_LINES = 32,
    parameter int LEG_A     = 0,
    parameter int LEG_B     = 8,
    localparam int RW       = $clog2(NUM_LINES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_CH-1:0]     ch_act,
    input  logic [NUM_CH*RW-1:0]  ch_route,
    input  logic                  mode_q,
    output logic [NUM_LINES-1:0]  tmr_lines
);
    logic [RW-1:0] eff_route [NUM_CH];

    // Effective route per channel: fixed lines for channels 0/1 in mode.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_eff
        if (c == 0) begin : g_c0
            assign eff_route[c] = mode_q ? RW'(LEG_A) : ch_route[c*RW +: RW];
        end else if (c == 1) begin : g_c1
            assign eff_route[c] = mode_q ? RW'(LEG_B) : ch_route[c*RW +: RW];
        end else begin : g_cn
            assign eff_route[c] = ch_route[c*RW +: RW];
        end
    end

    // Line decode: OR of every active channel routed to each line.
    always_comb begin
        tmr_lines = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_act[c]) tmr_lines[eff_route[c]] = 1'b1;
        end
    end

    AST_MODE_CH0: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q && ch_act[0]) |-> tmr_lines[LEG_A]);                  // R1
    AST_MODE_CH1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q && ch_act[1]) |-> tmr_lines[LEG_B]);                  // R1
    AST_FIELD_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && ch_act[NUM_CH-1]) |-> tmr_lines[ch_route[(NUM_CH-1)*RW +: RW]]); // R2
endmodule

// File: rtl/tir_legacy_gate.sv
// Module: registers the mode request and both legacy inputs, and gates the inputs.
// Assumes the legacy inputs are slow levels. One register of latency is acceptable.
module tir_legacy_gate #(
    parameter int NUM_LINES = 32,
    parameter int LEG_A     = 0,
    parameter int LEG_B     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode_req,
    input  logic                 in0,
    input  logic                 in1,
    output logic                 mode_q,
    output logic                 tick_en,
    output logic [NUM_LINES-1:0] leg_lines
);
    logic in0_q;
    logic in1_q;

    // Mode and input latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            in0_q  <= 1'b0;
            in1_q  <= 1'b0;
        end else begin
            mode_q <= mode_req;
            in0_q  <= in0;
            in1_q  <= in1;
        end
    end

    // Pass latched inputs only outside the mode.
    always_comb begin
        leg_lines        = '0;
        leg_lines[LEG_A] = in0_q && !mode_q;
        leg_lines[LEG_B] = in1_q && !mode_q;
    end

    assign tick_en = !mode_q;
endmodule

// File: rtl/tmr_irq_router.sv
// Module: top of the timer interrupt router.
// Holds per-channel status, routes channel activity to lines, and merges gated legacy inputs.
// Assumes expiry pulses are one cycle wide and synchronous to clk.
module tmr_irq_router
    import tir_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int RW    = TIR_ROUTEW
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_CH-1:0]     ch_expire,
    input  logic [NUM_CH*RW-1:0]  ch_route,
    input  logic [NUM_CH-1:0]     ch_level,
    input  logic [NUM_CH-1:0]     ch_enable,
    input  logic                  glb_enable,
    input  logic                  compat_mode,
    input  logic                  legacy_in0,
    input  logic                  legacy_in1,
    input  logic                  sts_wr,
    input  logic [NUM_CH-1:0]     sts_wdata,
    output logic [TIR_LINES-1:0]  irq_lines,
    output logic [NUM_CH-1:0]     irq_status,
    output logic                  legacy_tick_en
);
    logic [NUM_CH-1:0]    ch_act;
    logic [TIR_LINES-1:0] tmr_lines;
    logic [TIR_LINES-1:0] leg_lines;
    logic                 mode_q;

    // One status/pulse tracker per channel.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        tir_chan_state u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .expire   (ch_expire[c]),
            .ch_en    (ch_enable[c]),
            .glb_en   (glb_enable),
            .is_level (ch_level[c]),
            .clr_req  (sts_wr && sts_wdata[c]),
            .sts_q    (irq_status[c]),
            .act      (ch_act[c])
        );
    end

    tir_legacy_gate #(
        .NUM_LINES (TIR_LINES),
        .LEG_A     (TIR_LEG_A),
        .LEG_B     (TIR_LEG_B)
    ) u_leg (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_req  (compat_mode),
        .in0       (legacy_in0),
        .in1       (legacy_in1),
        .mode_q    (mode_q),
        .tick_en   (legacy_tick_en),
        .leg_lines (leg_lines)
    );

    tir_route_mux #(
        .NUM_CH    (NUM_CH),
        .NUM_LINES (TIR_LINES),
        .LEG_A     (TIR_LEG_A),
        .LEG_B     (TIR_LEG_B)
    ) u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .ch_act    (ch_act),
        .ch_route  (ch_route),
        .mode_q    (mode_q),
        .tmr_lines (tmr_lines)
    );

    // Output merge: timers and legacy sources share lines by OR.
    assign irq_lines = tmr_lines | leg_lines;

    AST_TICK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        compat_mode |=> !legacy_tick_en);                             // R8
    AST_TICK_ON: assert property (@(posedge clk) disable iff (!rst_n)
        !compat_mode |=> legacy_tick_en);                             // R8
    AST_PASS_B: assert property (@(posedge clk) disable iff (!rst_n)
        (!compat_mode && legacy_in1) |=> irq_lines[TIR_LEG_B]);       // R7
    AST_PASS_A: assert property (@(posedge clk) disable iff (!rst_n)
        (!compat_mode && legacy_in0) |=> irq_lines[TIR_LEG_A]);       // R7
endmodule

// File: tb/tmr_irq_router_bench.sv
module tmr_irq_router_bench;
    localparam int N  = 4;
    localparam int RW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  ch_expire = '0;
    logic [N*RW-1:0] ch_route = '0;
    logic [N-1:0]  ch_level = '0;
    logic [N-1:0]  ch_enable = '0;
    logic          glb_enable = 1'b0;
    logic          compat_mode = 1'b0;
    logic          legacy_in0 = 1'b0;
    logic          legacy_in1 = 1'b0;
    logic          sts_wr = 1'b0;
    logic [N-1:0]  sts_wdata = '0;
    logic [31:0]   irq_lines;
    logic [N-1:0]  irq_status;
    logic          legacy_tick_en;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    tmr_irq_router #(.NUM_CH(N)) u_tmr_irq_router (
        .clk(clk), .rst_n(rst_n), .ch_expire(ch_expire), .ch_route(ch_route),
        .ch_level(ch_level), .ch_enable(ch_enable), .glb_enable(glb_enable),
        .compat_mode(compat_mode), .legacy_in0(legacy_in0), .legacy_in1(legacy_in1),
        .sts_wr(sts_wr), .sts_wdata(sts_wdata), .irq_lines(irq_lines),
        .irq_status(irq_status), .legacy_tick_en(legacy_tick_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Advance one edge; inputs change and outputs are sampled at negedge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_route(input int c, input int line);
        ch_route[c*RW +: RW] = RW'(line);
    endtask

    task automatic pulse_expire(input int c);
        ch_expire[c] = 1'b1;
        step();
        ch_expire[c] = 1'b0;
    endtask

    task automatic t_reset();
        step(); step();
        rst_n = 1'b1;
        step();
        chk("R10 lines", irq_lines, 32'h0);
        chk("R10 status", 32'(irq_status), 32'h0);
        chk("R10 tick_en", 32'(legacy_tick_en), 32'h1);
    endtask

    task automatic t_level_and_clear();
        glb_enable = 1'b1; ch_enable = '1;
        ch_level[2] = 1'b1; set_route(2, 5);
        pulse_expire(2);
        chk("R3 status set", 32'(irq_status[2]), 32'h1);
        chk("R2 line 5", irq_lines, 32'h20);
        step(); step();
        chk("R3 line held", 32'(irq_lines[5]), 32'h1);
        sts_wr = 1'b1; sts_wdata = 4'b1011; step(); sts_wr = 1'b0;
        chk("R6 write0 keeps", 32'(irq_status[2]), 32'h1);
        sts_wr = 1'b1; sts_wdata = 4'b0100; step(); sts_wr = 1'b0;
        chk("R6 write1 clears", 32'(irq_status[2]), 32'h0);
        chk("R6 line lowered", 32'(irq_lines[5]), 32'h0);
        ch_expire[2] = 1'b1; sts_wr = 1'b1; sts_wdata = 4'b0100; step();
        ch_expire[2] = 1'b0; sts_wr = 1'b0;
        chk("R6 set wins", 32'(irq_status[2]), 32'h1);
        sts_wr = 1'b1; step(); sts_wr = 1'b0;
    endtask

    task automatic t_edge();
        ch_level[3] = 1'b0; set_route(3, 12);
        pulse_expire(3);
        chk("R4 pulse high", irq_lines, 32'h1000);
        chk("R4 status clear", 32'(irq_status[3]), 32'h0);
        step();
        chk("R4 pulse one cycle", irq_lines, 32'h0);
    endtask

    task automatic t_or_share();
        ch_level[2] = 1'b1; ch_level[3] = 1'b1;
        set_route(2, 20); set_route(3, 20);
        pulse_expire(2); pulse_expire(3);
        sts_wr = 1'b1; sts_wdata = 4'b0100; step(); sts_wr = 1'b0;
        chk("R9 shared line held", irq_lines, 32'h0010_0000);
    endtask

    task automatic t_disable();
        ch_enable[3] = 1'b0; step();
        chk("R5 chan off clears", 32'(irq_status[3]), 32'h0);
        chk("R5 line low", irq_lines, 32'h0);
        pulse_expire(3);
        chk("R5 expiry ignored", 32'(irq_status[3]), 32'h0);
        ch_enable[3] = 1'b1;
        pulse_expire(2);
        chk("R5 pre global", 32'(irq_status[2]), 32'h1);
        glb_enable = 1'b0; step();
        chk("R5 global clears", 32'(irq_status[2]), 32'h0);
        chk("R5 global line low", irq_lines, 32'h0);
        glb_enable = 1'b1;
    endtask

    task automatic t_passthru();
        legacy_in0 = 1'b1; step();
        chk("R7 in0 to line0", irq_lines, 32'h1);
        legacy_in1 = 1'b1; legacy_in0 = 1'b0; step();
        chk("R7 in1 to line8", irq_lines, 32'h100);
    endtask

    task automatic t_compat();
        compat_mode = 1'b1; step();
        chk("R8 tick off", 32'(legacy_tick_en), 32'h0);
        chk("R8 inputs blocked", irq_lines, 32'h0);
        ch_level[0] = 1'b1; set_route(0, 17);
        pulse_expire(0);
        chk("R1 ch0 on line0", irq_lines, 32'h1);
        sts_wr = 1'b1; sts_wdata = 4'b0001; step(); sts_wr = 1'b0;
        ch_level[1] = 1'b0; set_route(1, 3);
        pulse_expire(1);
        chk("R1 ch1 on line8", irq_lines, 32'h100);
        step();
        compat_mode = 1'b0; step();
        chk("R8 tick back", 32'(legacy_tick_en), 32'h1);
        chk("R8 line8 restored", irq_lines, 32'h100);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_level_and_clear();
                t_edge();
                t_or_share();
                t_disable();
                t_passthru();
                t_compat();
            end
            begin
                repeat (5000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule